// File: doc/BRIEF.md
# Clock-Gated FSM State Register

This block is the state register of a finite state machine, with the power-saving logic that belongs to it. The next-state vector comes from the machine's next-state logic. The block holds the current state and loads a new value on the falling clock edge. When the next state equals the current state, no clock edge reaches the register.

A small activation function compares the next state with the current state. Its result goes through a level-sensitive latch, which is open while the clock is low. The latch output is ANDed with the clock to form the register clock. The register therefore sees a falling edge only in cycles that change the state. Some targets cannot route a derived clock. For those, a parameter turns the same decision into a plain load enable on flip-flops that run from the free clock.

The current state is also driven out on a test observability port, for fault coverage and debug. A saturating counter records how many falling edges were held back, so a bench can see that gating happened during long waits. An asynchronous active-high reset forces the state to its reset code and clears the counter without waiting for any clock.

Top module: `fsm_state_gate`

## Requirements
- R1: On a falling edge of `clk` where `nxt_state` differs from `cur_state`, `cur_state` takes the value of `nxt_state`.
- R2: On a falling edge where `nxt_state` equals `cur_state`, `cur_state` keeps its value. In gated style the register receives no clock edge in that cycle.
- R3: `obs_state` always carries the same value as `cur_state`.
- R4: Each falling edge with `nxt_state` equal to `cur_state` raises `skip_cnt` by one. A falling edge that changes the state leaves `skip_cnt` unchanged.
- R5: `skip_cnt` saturates at its all-ones value (255 at the default width of 8 bits). Further held cycles leave it at that value.
- R6: While `rst` is high, `cur_state` equals `RESET_CODE` (default 0) and `skip_cnt` is 0. Both take these values as soon as `rst` rises, with no clock edge needed.
- R7: With `STYLE` set to the load-enable variant, `cur_state`, `obs_state` and `skip_cnt` follow the same cycle-by-cycle behaviour as in the gated-clock variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; the state loads on its falling edge |
| rst | input | 1 | Asynchronous reset, active high |
| nxt_state | input | SW | Next-state vector from the machine's next-state logic |
| cur_state | output | SW | Registered current state |
| obs_state | output | SW | Test observability copy of the current state |
| skip_cnt | output | CW | Saturating count of falling edges where the register clock was held back |

## Verification
The assertions sample on the falling clock edge. They take for granted that `nxt_state` settles during the low phase of `clk` and stays stable through the following high phase. Under that condition the latched enable and the comparison seen at the edge agree. They also assume that `rst` is released while `clk` is low, so that reset is not released within the same instant as an edge. The bench changes `nxt_state` and releases reset only one nanosecond after a falling edge, and reads outputs at that point too. It raises reset asynchronously in the middle of a high phase to show that the clear does not wait for a clock. Both register styles are driven with the same stimulus and checked against one model.

// File: rtl/fsg_pkg.sv
// Shared types for the clock-gated state register.
// Assumes: nothing beyond standard SystemVerilog.
package fsg_pkg;

    // How the register is kept from loading in idle cycles.
    typedef enum logic {
        GATE_CLOCK  = 1'b0,   // latch + AND derived register clock
        GATE_ENABLE = 1'b1    // free clock with a load enable
    } gate_style_e;

endpackage

// File: rtl/fsg_activation.sv
// Activation function: asserts wake when the next state differs from
// the current state. Kept to one XOR per bit and an OR tree.
// Assumes: both vectors are settled before the clock rises.
module fsg_activation #(
    parameter int SW = 4
) (
    input  logic [SW-1:0] nxt,
    input  logic [SW-1:0] cur,
    output logic          wake
);

    // Per-bit difference reduced to one wake bit.
    always_comb begin
        wake = |(nxt ^ cur);
    end

endmodule

// File: rtl/fsg_clk_gate.sv
// Glitch-free clock gate: the enable is held in a latch that is open
// while clk is low. The latch output is ANDed with clk, so the derived
// clock pulses high only for a full high phase of clk.
// Assumes: en is settled before clk rises.
module fsg_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gck
);

    logic en_hold;

    // Capture the enable during the low phase; hold it while clk is high.
    always_latch begin
        if (!clk) begin
            en_hold = en;
        end
    end

    // Pass clk only when the held enable is set.
    assign gck = clk & en_hold;

endmodule

// File: rtl/fsg_state_reg.sv
// State register that loads on the falling edge. Either a derived clock
// from the latch + AND cell drives it, or a free clock with a load enable
// does, as STYLE selects. Reset is asynchronous and active high, and
// does not depend on the derived clock.
// Assumes: wake is stable across the high phase of clk.
module fsg_state_reg
    import fsg_pkg::*;
#(
    parameter int               SW         = 4,
    parameter logic [SW-1:0]    RESET_CODE = '0,
    parameter gate_style_e      STYLE      = GATE_CLOCK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake,
    input  logic [SW-1:0] nxt,
    output logic [SW-1:0] cur
);

    generate
        if (STYLE == GATE_CLOCK) begin : g_gated
            logic gck;

            fsg_clk_gate u_gate (
                .clk (clk),
                .en  (wake),
                .gck (gck)
            );

            // Load on each falling edge of the derived clock; clear at once on reset.
            always_ff @(negedge gck or posedge rst) begin
                if (rst) begin
                    cur <= RESET_CODE;
                end else begin
                    cur <= nxt;
                end
            end
        end else begin : g_enable
            // Load on a falling edge of clk only when wake is set; clear at once on reset.
            always_ff @(negedge clk or posedge rst) begin
                if (rst) begin
                    cur <= RESET_CODE;
                end else if (wake) begin
                    cur <= nxt;
                end
            end
        end
    endgenerate

    // R1: a differing next state is loaded at the falling edge.
    a_r1_load_on_change: assert property (
        @(negedge clk) disable iff (rst)
        (nxt != cur) |=> (cur == $past(nxt))
    );

    // R2: an equal next state leaves the register untouched.
    a_r2_hold_when_equal: assert property (
        @(negedge clk) disable iff (rst)
        (nxt == cur) |=> $stable(cur)
    );

endmodule

// File: rtl/fsg_skip_cnt.sv
// Saturating count of falling edges where the register was kept from
// loading. Runs on the free clock, cleared by the asynchronous reset.
// Assumes: wake is stable across the high phase of clk.
module fsg_skip_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Add one per held-back edge, stop at all ones.
    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            cnt <= '0;
        end else if (!wake && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: a held-back edge below saturation adds exactly one.
    a_r4_count_idle: assert property (
        @(negedge clk) disable iff (rst)
        (!wake && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1)
    );

    // R4: an edge that loads the state does not count.
    a_r4_no_count_on_load: assert property (
        @(negedge clk) disable iff (rst)
        wake |=> $stable(cnt)
    );

    // R5: once saturated the count stays there.
    a_r5_saturate: assert property (
        @(negedge clk) disable iff (rst)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX)
    );

endmodule

// File: rtl/fsm_state_gate.sv
// Top of the clock-gated FSM state register. Ties the activation
// function, the state register (gated clock or load enable), the test
// observability copy and the skipped-edge counter together.
// Assumes: nxt_state settles while clk is low; rst is released while clk is low.
module fsm_state_gate
    import fsg_pkg::*;
#(
    parameter int            SW         = 4,
    parameter int            CW         = 8,
    parameter logic [SW-1:0] RESET_CODE = '0,
    parameter gate_style_e   STYLE      = GATE_CLOCK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] nxt_state,
    output logic [SW-1:0] cur_state,
    output logic [SW-1:0] obs_state,
    output logic [CW-1:0] skip_cnt
);

    logic wake;

    fsg_activation #(.SW(SW)) u_act (
        .nxt  (nxt_state),
        .cur  (cur_state),
        .wake (wake)
    );

    fsg_state_reg #(
        .SW         (SW),
        .RESET_CODE (RESET_CODE),
        .STYLE      (STYLE)
    ) u_reg (
        .clk  (clk),
        .rst  (rst),
        .wake (wake),
        .nxt  (nxt_state),
        .cur  (cur_state)
    );

    fsg_skip_cnt #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .wake (wake),
        .cnt  (skip_cnt)
    );

    // Test observability copy of the state.
    assign obs_state = cur_state;

endmodule

// File: tb/sim_fsm_state_gate.sv
// Directed bench: both register styles get the same stimulus and are
// checked against one model of the requirements.
module sim_fsm_state_gate;
    import fsg_pkg::*;

    localparam int SW = 4;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] nxt_state = '0;
    logic [SW-1:0] cur0, obs0, cur1, obs1;
    logic [CW-1:0] cnt0, cnt1;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_cur = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    fsm_state_gate #(.SW(SW), .CW(CW), .STYLE(GATE_CLOCK)) u0 (
        .clk (clk), .rst (rst), .nxt_state (nxt_state),
        .cur_state (cur0), .obs_state (obs0), .skip_cnt (cnt0)
    );

    fsm_state_gate #(.SW(SW), .CW(CW), .STYLE(GATE_ENABLE)) u1 (
        .clk (clk), .rst (rst), .nxt_state (nxt_state),
        .cur_state (cur1), .obs_state (obs1), .skip_cnt (cnt1)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Compare both instances with the model (R7 covers the enable variant).
    task automatic chk_all(input string tag);
        chk({tag, " R1/R2 cur gated"}, int'(cur0), exp_cur);
        chk({tag, " R3 obs gated"},    int'(obs0), exp_cur);
        chk({tag, " R4 cnt gated"},    int'(cnt0), exp_cnt);
        chk({tag, " R7 cur enable"},   int'(cur1), exp_cur);
        chk({tag, " R7 obs enable"},   int'(obs1), exp_cur);
        chk({tag, " R7 cnt enable"},   int'(cnt1), exp_cnt);
    endtask

    // One falling edge with a given next state; the model follows R1, R2, R4, R5.
    task automatic tick(input int v);
        nxt_state = SW'(v);
        @(negedge clk);
        #1;
        if (v != exp_cur) exp_cur = v;
        else if (exp_cnt != CMAX) exp_cnt++;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        nxt_state = 4'd9;
        repeat (3) @(negedge clk);
        #1;
        exp_cur = 0; exp_cnt = 0;
        chk_all("R6 reset hold");
        rst = 1'b0;
    endtask

    task automatic t_load;
        tick(5);  chk_all("R1 load 5");
        tick(10); chk_all("R1 load 10");
        tick(15); chk_all("R1 load 15");
        tick(1);  chk_all("R1 load 1");
        tick(0);  chk_all("R1 load 0");
    endtask

    task automatic t_hold;
        tick(6); chk_all("R1 enter 6");
        for (int i = 0; i < 10; i++) tick(6);
        chk_all("R2 hold 6 x10");
        chk("R4 ten idle edges", int'(cnt0), 10);
        tick(3); chk_all("R4 load after hold");
    endtask

    task automatic t_mixed;
        tick(3); tick(12); tick(12); tick(7); tick(7); tick(7); tick(2);
        chk_all("R4 mixed pattern");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < CMAX + 20; i++) tick(2);
        chk_all("R5 saturated");
        chk("R5 all ones", int'(cnt0), CMAX);
        tick(9); chk_all("R5 load at saturation");
    endtask

    task automatic t_async_reset;
        @(posedge clk);
        #1;
        rst = 1'b1;
        #1;
        exp_cur = 0; exp_cnt = 0;
        chk_all("R6 async clear");
        @(negedge clk);
        #1;
        rst = 1'b0;
        tick(4); chk_all("R6 run after reset");
        tick(4); chk_all("R6 count after reset");
    endtask

    initial begin
        #1;
        t_reset();
        t_load();
        t_hold();
        t_mixed();
        t_saturate();
        t_async_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule